// File: doc/BRIEF.md
# Two-Digit Decimal Event Counter

This block counts enabled clock cycles in decimal, from 00 to 99, and then wraps back to 00. It is made of two identical decade stages. The first stage holds the units digit and the second holds the tens digit. Both stages run on the same clock. The units stage advances on every enabled clock. The tens stage advances only on a clock where the units stage reports that it is about to wrap.

Each stage finds its next value from per-bit toggle conditions instead of an adder. Each stage has a terminal-count flag, which is high in the cycle before that stage wraps to zero. The flags are also registered, which gives two rate outputs. The first pulses once every ten enabled counts. The second pulses once every hundred.

A parent design uses the digits as a readable decimal tally. It uses the rate outputs as divide-by-10 and divide-by-100 strobes.

Top module: `bcd_mod100_counter`

## Requirements
- R1: When `rst` is high at a rising clock edge, both digits become 0000 and both rate outputs become 0 after that edge. This holds whatever `cnt_en` is.
- R2: On each rising edge with `rst` low and `cnt_en` high, the units digit steps 0,1,...,9 in binary-coded decimal. From 9 (1001) it returns to 0 (0000).
- R3: The tens digit changes only on an edge where `units_tc` is high. On that edge it steps by one in decimal, and it goes from 9 back to 0.
- R4: `units_tc` is high in the same cycle exactly when `cnt_en` is 1 and the units digit is 1001.
- R5: `tens_tc` is high in the same cycle exactly when `cnt_en` is 1 and both digits are 1001.
- R6: While `cnt_en` is 0, both digits keep their value across clock edges, and both `units_tc` and `tens_tc` are 0.
- R7: `div10_pulse` is 1 for the cycle right after an edge at which `units_tc` was 1. At all other times it is 0.
- R8: `div100_pulse` is 1 for the cycle right after an edge at which `tens_tc` was 1. At all other times it is 0.
- R9: After reset, N enabled clocks leave the two digits equal to N modulo 100 in decimal. Over that run, `div10_pulse` pulses floor(N/10) times and `div100_pulse` pulses floor(N/100) times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all registers |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable for the units stage |
| units | output | 4 | Units digit, BCD |
| tens | output | 4 | Tens digit, BCD |
| units_tc | output | 1 | Units stage is at 9 and enabled |
| tens_tc | output | 1 | Both stages are at 9 and enabled |
| div10_pulse | output | 1 | Registered units terminal count, one pulse per ten counts |
| div100_pulse | output | 1 | Registered tens terminal count, one pulse per hundred counts |

## Verification
The counter is driven through a table of segments, each ending in a known digit pair:
- long enabled runs that cross the 9-to-0 boundary of the units digit, which show that the carry reaches the tens stage;
- an enabled run that lands on 99 and then one more step, which shows the full wrap to 00;
- disabled gaps in the middle of the count, which separate holding from counting;
- a reset asserted together with the enable, which shows that reset takes priority.

A run of 250 enabled clocks is then compared every cycle against a modulo-100 integer model. The pulses on each rate output are tallied, which tells correct division apart from extra or missing strobes.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int DIGIT_W  = 4;
  localparam int RADIX    = 10;
  localparam int N_DIGITS = 2;
  typedef logic [DIGIT_W-1:0] digit_t;
  localparam digit_t LAST_DIGIT = digit_t'(RADIX - 1);
endpackage

// File: rtl/bcd_decade.sv
module bcd_decade
  import bcd_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   step_en,
  output digit_t digit,
  output logic   wrap_next
);
  digit_t q;
  digit_t tgl;

  // toggle conditions for a decimal stage
  always_comb begin
    tgl[0] = 1'b1;
    tgl[1] = ~q[3] & q[0];
    tgl[2] = q[1] & q[0];
    tgl[3] = (q[2] & q[1] & q[0]) | (q[3] & q[0]);
  end

  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (step_en)
      q <= q ^ tgl;
  end

  assign digit     = q;
  assign wrap_next = step_en & (q == LAST_DIGIT);
endmodule

// File: rtl/rate_taps.sv
module rate_taps #(
  parameter int TAPS = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TAPS-1:0] tc_in,
  output logic [TAPS-1:0] pulse_out
);
  always_ff @(posedge clk) begin
    if (rst)
      pulse_out <= '0;
    else
      pulse_out <= tc_in;
  end
endmodule

// File: rtl/bcd_mod100_counter.sv
module bcd_mod100_counter
  import bcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cnt_en,
  output logic [3:0] units,
  output logic [3:0] tens,
  output logic       units_tc,
  output logic       tens_tc,
  output logic       div10_pulse,
  output logic       div100_pulse
);
  digit_t              digs  [N_DIGITS];
  logic [N_DIGITS:0]   chain;
  logic [N_DIGITS-1:0] pulses;

  assign chain[0] = cnt_en;

  // each stage is enabled by the terminal count of the stage below it
  for (genvar g = 0; g < N_DIGITS; g++) begin : g_stage
    bcd_decade u_dec (
      .clk       (clk),
      .rst       (rst),
      .step_en   (chain[g]),
      .digit     (digs[g]),
      .wrap_next (chain[g+1])
    );
  end

  rate_taps #(.TAPS(N_DIGITS)) u_taps (
    .clk       (clk),
    .rst       (rst),
    .tc_in     (chain[N_DIGITS:1]),
    .pulse_out (pulses)
  );

  assign units        = digs[0];
  assign tens         = digs[1];
  assign units_tc     = chain[1];
  assign tens_tc      = chain[2];
  assign div10_pulse  = pulses[0];
  assign div100_pulse = pulses[1];
endmodule

// File: rtl/bcd_mod100_checker.sv
module bcd_mod100_checker (
  input logic       clk,
  input logic       rst,
  input logic       cnt_en,
  input logic [3:0] units,
  input logic [3:0] tens,
  input logic       units_tc,
  input logic       tens_tc,
  input logic       div10_pulse,
  input logic       div100_pulse
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (units == 4'd0 && tens == 4'd0 && !div10_pulse && !div100_pulse));

  a_r2_units_step: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && units != 4'd9) |=> units == $past(units) + 4'd1);

  a_r4_units_wrap: assert property (@(posedge clk) disable iff (rst)
    units_tc |=> units == 4'd0);

  a_r3_tens_hold: assert property (@(posedge clk) disable iff (rst)
    !units_tc |=> $stable(tens));

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> ($stable(units) && $stable(tens)));

  a_r6_idle_no_tc: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |-> (!units_tc && !tens_tc));

  a_r7_div10: assert property (@(posedge clk) disable iff (rst)
    units_tc |=> div10_pulse);

  a_r8_div100: assert property (@(posedge clk) disable iff (rst)
    tens_tc |=> (div100_pulse && tens == 4'd0));
endmodule

bind bcd_mod100_counter bcd_mod100_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .cnt_en       (cnt_en),
  .units        (units),
  .tens         (tens),
  .units_tc     (units_tc),
  .tens_tc      (tens_tc),
  .div10_pulse  (div10_pulse),
  .div100_pulse (div100_pulse)
);

// File: tb/sim_bcd_mod100_counter.sv
module sim_bcd_mod100_counter;
  localparam int CLK_PERIOD = 10;
  localparam int N_SEG = 10;
  // {rst, en, cycles[7:0], exp_tens[3:0], exp_units[3:0]}
  localparam logic [17:0] SEGS [N_SEG] = '{
    {1'b1, 1'b0, 8'd2,  4'd0, 4'd0},
    {1'b0, 1'b1, 8'd7,  4'd0, 4'd7},
    {1'b0, 1'b0, 8'd5,  4'd0, 4'd7},
    {1'b0, 1'b1, 8'd3,  4'd1, 4'd0},
    {1'b0, 1'b1, 8'd45, 4'd5, 4'd5},
    {1'b0, 1'b0, 8'd1,  4'd5, 4'd5},
    {1'b1, 1'b1, 8'd1,  4'd0, 4'd0},
    {1'b0, 1'b1, 8'd99, 4'd9, 4'd9},
    {1'b0, 1'b1, 8'd1,  4'd0, 4'd0},
    {1'b0, 1'b1, 8'd12, 4'd1, 4'd2}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_en = 1'b0;
  logic [3:0] units, tens;
  logic units_tc, tens_tc, div10_pulse, div100_pulse;

  int checks = 0;
  int fails = 0;
  int mu = 0, mt = 0;
  bit p10 = 0, p100 = 0;
  int n10 = 0, n100 = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_mod100_counter u0 (
    .clk(clk), .rst(rst), .cnt_en(cnt_en),
    .units(units), .tens(tens),
    .units_tc(units_tc), .tens_tc(tens_tc),
    .div10_pulse(div10_pulse), .div100_pulse(div100_pulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: drive, check flags before the edge, update model, check after
  task automatic step(input bit r, input bit e);
    bit etc_u, etc_t;
    @(negedge clk);
    rst = r;
    cnt_en = e;
    #1;
    etc_u = e && (mu == 9);
    etc_t = etc_u && (mt == 9);
    chk("R4 units_tc", int'(units_tc), int'(etc_u));
    chk("R5 tens_tc", int'(tens_tc), int'(etc_t));
    if (!e) chk("R6 tc low while idle", int'(units_tc | tens_tc), 0);
    if (r) begin
      mu = 0; mt = 0; p10 = 0; p100 = 0;
    end else begin
      p10 = etc_u; p100 = etc_t;
      if (e) mu = (mu + 1) % 10;
      if (etc_u) mt = (mt + 1) % 10;
    end
    @(posedge clk);
    #1;
    chk("R2 units", int'(units), mu);
    chk("R3 tens", int'(tens), mt);
    chk("R7 div10_pulse", int'(div10_pulse), int'(p10));
    chk("R8 div100_pulse", int'(div100_pulse), int'(p100));
    if (div10_pulse) n10++;
    if (div100_pulse) n100++;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    step(1'b1, 1'b1);
    chk("R1 reset units", int'(units), 0);
    chk("R1 reset tens", int'(tens), 0);
    chk("R1 reset pulses", int'(div10_pulse | div100_pulse), 0);

    // table of segments
    for (int s = 0; s < N_SEG; s++) begin
      for (int c = 0; c < int'(SEGS[s][15:8]); c++)
        step(SEGS[s][17], SEGS[s][16]);
      chk("R9 table tens", int'(tens), int'(SEGS[s][7:4]));
      chk("R9 table units", int'(units), int'(SEGS[s][3:0]));
    end

    // R6 idle hold at a nonzero value
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk("R6 hold units", int'(units), 2);
    chk("R6 hold tens", int'(tens), 1);

    // R9 long run from reset: 250 enabled clocks
    step(1'b1, 1'b0);
    n10 = 0; n100 = 0;
    for (int i = 0; i < 250; i++) step(1'b0, 1'b1);
    chk("R9 final tens", int'(tens), 5);
    chk("R9 final units", int'(units), 0);
    chk("R9 div10 pulse count", n10, 25);
    chk("R9 div100 pulse count", n100, 2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule